// File: doc/BRIEF.md
# Calibration Pulse Injection Sequencer

This block sits in a front-end controller and turns calibration commands from the fast-control command stream into injection strobes. A calibration command carries a two-bit type. Type 0 is the general-purpose flavour and has a fixed delay set at build time. Types 1 to 3 are meant for local tests and use a programmable delay. Each command that is taken fires one strobe on exactly one channel group. The next command fires the next group, and the selection wraps over a programmable number of groups, so all channels never pulse together.

Within a group, even and odd channels are injected with opposite polarity. That pairing flips on every pulse. The cycle after each strobe, the block raises a calibration trigger tag. The tag carries the command type and a flag that tells the readout to skip zero-suppression for that event. A local disable silences injection completely while commands are still decoded and counted. A command that arrives while an earlier one is still waiting out its delay is dropped and counted. Software sets up the block through a small register port, and every register can be read back.

Top module: `calib_inject_seq`

## Requirements
- R1: After reset the following hold. All strobes and the tag are low. pol_even is 0 and pol_odd is 1. The group count register reads NGRP-1, the type mask reads 1, the control register reads 0 and the delay register reads 0. Both counters read 0.
- R2: The command decoder works as follows.
  - A sampled byte whose upper nibble is 0xA is a calibration command. Its type is bits 1:0, and bits 3:2 are ignored.
  - The command is taken only if bit <type> of the type mask is set.
  - A byte whose upper nibble is 0xC is a group-reset command.
  - Every other byte has no effect.
- R3: Let D be the delay: T0_DLY (default 3) for type 0, or the delay register (0 to 15) for types 1 to 3. The strobe is high for the single cycle that begins at rising edge D+1 after the edge that sampled the command.
- R4: grp_strobe has at most one bit set and is never high for two cycles in a row.
- R5: Successive pulses walk the groups 0,1,...,G-1 and then wrap to 0. G is the group count register (address 0, bits 3:0) plus one. A group-reset command, or any write to address 0, returns the next pulse to group 0 with polarity phase 0.
- R6: pol_odd is always the inverse of pol_even. The two signals change only when a strobe is issued. pol_even is 0 on the first pulse after reset or after a group reset, and it toggles on each pulse after that.
- R7: tag_valid is high for the cycle right after each strobe, and at no other time. tag_type carries the type of the command that fired. tag_nozs equals control bit 1 (skip zero-suppression) during that cycle.
- R8: While control bit 0 (disable) is set, the following hold.
  - No strobe, tag, pointer step or polarity flip occurs.
  - A pulse that falls due is discarded.
  - Enabled calibration commands still increment the accepted counter (address 4).
- R9: An enabled calibration command, taken while the block is enabled, makes the block pending from edge k+1 to edge k+1+D, where k is the edge that sampled it. A further enabled command sampled at any of those edges is dropped without a pulse. The drop increments the overflow counter (address 5) and not the accepted counter.
- R10: The register port works as follows.
  - Writes take effect at the edge that samples cfg_we. Writes to addresses 4 and 5 are ignored.
  - cfg_rdata shows the register at cfg_addr as it stood before the sampling edge, from that edge onward.
  - Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Fast-control command byte |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| grp_strobe | output | NGRP | One-hot per-group injection strobe |
| pol_even | output | 1 | Polarity for even channels of the strobed group |
| pol_odd | output | 1 | Polarity for odd channels of the strobed group |
| tag_valid | output | 1 | Calibration trigger tag |
| tag_type | output | 2 | Type of the command that fired |
| tag_nozs | output | 1 | Skip zero-suppression for the tagged event |

## Verification
A corrupted group pointer shows up on the very next strobe as the wrong bit of grp_strobe. A stuck or lost polarity phase shows on the next pulse as pol_even failing to alternate. A wrong delay counter moves the strobe off its cycle. It also shifts the window in which later commands land in the overflow counter, and that is visible in a read of address 5 a cycle after the drop. The bench runs a cycle-level reference next to the design and compares every output on every cycle. Any divergence is therefore reported in the first cycle it reaches a port.

// File: rtl/calib_pkg.sv
package calib_pkg;
  localparam logic [3:0] OP_CAL  = 4'hA;
  localparam logic [3:0] OP_GRST = 4'hC;

  typedef enum logic [2:0] {
    RA_NGRP = 3'd0,
    RA_MASK = 3'd1,
    RA_CTRL = 3'd2,
    RA_DLY  = 3'd3,
    RA_ACC  = 3'd4,
    RA_OVF  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic       cal;
    logic       grst;
    logic [1:0] typ;
  } cmd_t;
endpackage

// File: rtl/calib_cfg.sv
module calib_cfg
  import calib_pkg::*;
#(
  parameter int GW   = 4,
  parameter int DLYW = 4,
  parameter int CNTW = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic            acc_inc,
  input  logic            ovf_inc,
  output logic [GW-1:0]   ngrp_m1,
  output logic [3:0]      type_en,
  output logic            dis,
  output logic            skipzs,
  output logic [DLYW-1:0] dly,
  output logic            grp_wr,
  output logic [DW-1:0]   rdata
);
  logic [CNTW-1:0] acc_cnt, ovf_cnt;
  logic unused_wd;
  assign unused_wd = ^wdata;

  assign grp_wr = we && (addr == RA_NGRP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ngrp_m1 <= '1;
      type_en <= 4'b0001;
      dis     <= 1'b0;
      skipzs  <= 1'b0;
      dly     <= '0;
      acc_cnt <= '0;
      ovf_cnt <= '0;
      rdata   <= '0;
    end else begin
      if (we) begin
        case (reg_addr_e'(addr))
          RA_NGRP: ngrp_m1 <= wdata[GW-1:0];
          RA_MASK: type_en <= wdata[3:0];
          RA_CTRL: begin
            dis    <= wdata[0];
            skipzs <= wdata[1];
          end
          RA_DLY:  dly <= wdata[DLYW-1:0];
          default: ;
        endcase
      end
      if (acc_inc) acc_cnt <= acc_cnt + 1'b1;
      if (ovf_inc) ovf_cnt <= ovf_cnt + 1'b1;
      case (reg_addr_e'(addr))
        RA_NGRP: rdata <= DW'(ngrp_m1);
        RA_MASK: rdata <= DW'(type_en);
        RA_CTRL: rdata <= DW'({skipzs, dis});
        RA_DLY:  rdata <= DW'(dly);
        RA_ACC:  rdata <= DW'(acc_cnt);
        RA_OVF:  rdata <= DW'(ovf_cnt);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/calib_timer.sv
module calib_timer #(
  parameter int DLYW   = 4,
  parameter int T0_DLY = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      start_typ,
  input  logic [DLYW-1:0] prog_dly,
  output logic            pend,
  output logic            fire,
  output logic [1:0]      typ_q
);
  logic [DLYW-1:0] cnt;

  assign fire = pend && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      cnt   <= '0;
      typ_q <= 2'd0;
    end else begin
      if (fire)      pend <= 1'b0;
      else if (pend) cnt  <= cnt - 1'b1;
      if (start) begin
        pend  <= 1'b1;
        cnt   <= (start_typ == 2'd0) ? DLYW'(T0_DLY) : prog_dly;
        typ_q <= start_typ;
      end
    end
  end
endmodule

// File: rtl/calib_rr.sv
module calib_rr #(
  parameter int NGRP = 16,
  parameter int GW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            clr,
  input  logic [GW-1:0]   last,
  output logic [NGRP-1:0] strobe,
  output logic            pol_even,
  output logic            pol_odd
);
  logic [GW-1:0]   ptr;
  logic            phase;
  logic [NGRP-1:0] hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    assign hit[g] = fire && (ptr == GW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      phase    <= 1'b0;
      strobe   <= '0;
      pol_even <= 1'b0;
      pol_odd  <= 1'b1;
    end else begin
      strobe <= hit;
      if (fire) begin
        pol_even <= phase;
        pol_odd  <= ~phase;
        phase    <= ~phase;
        ptr      <= (ptr == last) ? '0 : ptr + 1'b1;
      end
      if (clr) begin
        ptr   <= '0;
        phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/calib_inject_seq.sv
module calib_inject_seq
  import calib_pkg::*;
#(
  parameter int NGRP   = 16,
  parameter int DLYW   = 4,
  parameter int CNTW   = 8,
  parameter int T0_DLY = 3,
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  output logic [NGRP-1:0] grp_strobe,
  output logic            pol_even,
  output logic            pol_odd,
  output logic            tag_valid,
  output logic [1:0]      tag_type,
  output logic            tag_nozs
);
  cmd_t            dc;
  logic [GW-1:0]   ngrp_m1;
  logic [3:0]      type_en;
  logic            cfg_dis, cfg_skipzs, grp_wr;
  logic [DLYW-1:0] cfg_dly;
  logic            pend, t_fire, cal_ok, start;
  logic [1:0]      t_typ;
  logic            unused_cmd;

  assign unused_cmd = ^cmd_byte;
  assign dc.cal  = cmd_valid && (cmd_byte[7:4] == OP_CAL);
  assign dc.grst = cmd_valid && (cmd_byte[7:4] == OP_GRST);
  assign dc.typ  = cmd_byte[1:0];

  assign cal_ok = dc.cal && type_en[dc.typ];
  assign start  = cal_ok && !cfg_dis && !pend;

  calib_cfg #(.GW(GW), .DLYW(DLYW), .CNTW(CNTW), .DW(8)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .acc_inc(cal_ok && (cfg_dis || !pend)),
    .ovf_inc(cal_ok && !cfg_dis && pend),
    .ngrp_m1(ngrp_m1), .type_en(type_en), .dis(cfg_dis), .skipzs(cfg_skipzs),
    .dly(cfg_dly), .grp_wr(grp_wr), .rdata(cfg_rdata)
  );

  calib_timer #(.DLYW(DLYW), .T0_DLY(T0_DLY)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .start_typ(dc.typ),
    .prog_dly(cfg_dly), .pend(pend), .fire(t_fire), .typ_q(t_typ)
  );

  calib_rr #(.NGRP(NGRP), .GW(GW)) u_rr (
    .clk(clk), .rst(rst), .fire(t_fire && !cfg_dis), .clr(dc.grst || grp_wr),
    .last(ngrp_m1), .strobe(grp_strobe), .pol_even(pol_even), .pol_odd(pol_odd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_valid <= 1'b0;
      tag_type  <= 2'd0;
      tag_nozs  <= 1'b0;
    end else begin
      tag_valid <= |grp_strobe;
      tag_type  <= t_typ;
      tag_nozs  <= (|grp_strobe) && cfg_skipzs;
    end
  end
endmodule

// File: rtl/calib_inject_chk.sv
module calib_inject_chk #(
  parameter int NGRP = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NGRP-1:0] grp_strobe,
  input logic            pol_even,
  input logic            pol_odd,
  input logic            tag_valid,
  input logic            dis
);
  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_strobe));
  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (|grp_strobe) |=> !(|grp_strobe));
  // R6
  pol_compl_chk: assert property (@(posedge clk) disable iff (rst)
    pol_even != pol_odd);
  // R7
  tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|grp_strobe) |=> tag_valid);
  // R7
  tag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> $past(|grp_strobe));
  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dis) |-> !(|grp_strobe));
endmodule

bind calib_inject_seq calib_inject_chk #(.NGRP(NGRP)) u_chk (
  .clk(clk), .rst(rst), .grp_strobe(grp_strobe), .pol_even(pol_even),
  .pol_odd(pol_odd), .tag_valid(tag_valid), .dis(cfg_dis)
);

// File: tb/sim_calib_inject_seq.sv
`timescale 1ns/1ps
module sim_calib_inject_seq;
  localparam int NG = 16;
  localparam int T0 = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cfg_we = 1'b0;
  logic [7:0] cmd_byte = '0, cfg_wdata = '0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_rdata;
  logic [NG-1:0] grp_strobe;
  logic pol_even, pol_odd, tag_valid, tag_nozs;
  logic [1:0] tag_type;

  calib_inject_seq #(.NGRP(NG), .T0_DLY(T0)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  string sect = "R1 reset";

  // reference model state
  logic [3:0] m_ng = 4'hF, m_mask = 4'b0001, m_dly = '0, m_cnt = '0, m_ptr = '0;
  logic m_dis = 0, m_skz = 0, m_pend = 0, m_phase = 0;
  logic [1:0] m_type = '0;
  logic [7:0] m_acc = '0, m_ovf = '0;
  logic [NG-1:0] e_strobe = '0;
  logic e_pe = 0, e_po = 1, e_tag = 0, e_nozs = 0;
  logic [1:0] e_ttype = '0;
  logic [7:0] e_rdata = '0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s]: got %0h expected %0h", what, sect, act, exp);
    end
  endtask

  task automatic compare();
    chk("R4 strobe", grp_strobe, e_strobe);
    chk("R6 pol_even", pol_even, e_pe);
    chk("R6 pol_odd", pol_odd, e_po);
    chk("R7 tag_valid", tag_valid, e_tag);
    chk("R7 tag_type", tag_type, e_ttype);
    chk("R7 tag_nozs", tag_nozs, e_nozs);
    chk("R10 rdata", cfg_rdata, e_rdata);
  endtask

  function automatic logic [7:0] rd_model(logic [2:0] a);
    case (a)
      3'd0: return {4'b0, m_ng};
      3'd1: return {4'b0, m_mask};
      3'd2: return {6'b0, m_skz, m_dis};
      3'd3: return {4'b0, m_dly};
      3'd4: return m_acc;
      3'd5: return m_ovf;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    logic fire, cal, ok, grst;
    logic [1:0] typ;
    e_rdata = rd_model(cfg_addr);
    e_tag   = |e_strobe;
    e_nozs  = (|e_strobe) && m_skz;
    e_ttype = m_type;
    fire = m_pend && (m_cnt == 0);
    e_strobe = '0;
    cal  = cmd_valid && cmd_byte[7:4] == 4'hA;
    grst = cmd_valid && cmd_byte[7:4] == 4'hC;
    typ  = cmd_byte[1:0];
    ok   = cal && m_mask[typ];
    if (ok) begin
      if (m_dis) m_acc++;
      else if (m_pend) m_ovf++;
    end
    if (fire) begin
      m_pend = 0;
      if (!m_dis) begin
        e_strobe = NG'(1) << m_ptr;
        e_pe = m_phase;
        e_po = !m_phase;
        m_ptr = (m_ptr == m_ng) ? 4'd0 : m_ptr + 4'd1;
        m_phase = !m_phase;
      end
    end else if (m_pend) m_cnt = m_cnt - 1;
    if (ok && !m_dis && !(m_pend || fire)) begin
      m_acc++;
      m_pend = 1;
      m_cnt = (typ == 0) ? 4'(T0) : m_dly;
      m_type = typ;
    end
    if (grst || (cfg_we && cfg_addr == 3'd0)) begin
      m_ptr = 0;
      m_phase = 0;
    end
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_ng = cfg_wdata[3:0];
        3'd1: m_mask = cfg_wdata[3:0];
        3'd2: begin m_dis = cfg_wdata[0]; m_skz = cfg_wdata[1]; end
        3'd3: m_dly = cfg_wdata[3:0];
        default: ;
      endcase
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(logic v, logic [7:0] b, logic we, logic [2:0] a, logic [7:0] wd);
    cmd_valid = v; cmd_byte = b; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'd0, 8'h00);
  endtask

  task automatic cmd(logic [7:0] b);
    step(1, b, 0, 3'd0, 8'h00);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(0, 8'h00, 1, a, d);
  endtask

  task automatic rd(logic [2:0] a);
    step(0, 8'h00, 0, a, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired [%s]", sect);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 0;
    sect = "R1 reset";
    compare();
    for (int a = 0; a < 8; a++) rd(3'(a));

    sect = "R10 readback";
    wr(3'd1, 8'hFF); wr(3'd3, 8'h07); wr(3'd2, 8'h02); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
    for (int a = 0; a < 8; a++) rd(3'(a));

    sect = "R3 type0 fixed delay";
    cmd(8'hA0); idle(8);
    sect = "R3 type1 delay 7";
    cmd(8'hAD); idle(12);
    sect = "R3 delay 0";
    wr(3'd3, 8'h00); cmd(8'hA2); idle(4);
    sect = "R3 delay 15";
    wr(3'd3, 8'h0F); cmd(8'hA3); idle(20);

    sect = "R9 overflow";
    wr(3'd3, 8'h02);
    cmd(8'hA1); cmd(8'hA1); cmd(8'hA2); cmd(8'hA3); cmd(8'hA1); idle(6);
    rd(3'd5); rd(3'd4);

    sect = "R5 single group";
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    for (int i = 0; i < 4; i++) begin cmd(8'hA1); idle(2); end
    sect = "R5 three groups wrap";
    wr(3'd0, 8'h02);
    for (int i = 0; i < 7; i++) begin cmd(8'hA1); idle(2); end
    sect = "R5 group reset command";
    cmd(8'hC3); idle(1);
    for (int i = 0; i < 3; i++) begin cmd(8'hA2); idle(2); end

    sect = "R8 disable";
    wr(3'd2, 8'h03);
    for (int i = 0; i < 4; i++) begin cmd(8'hA1); idle(2); end
    rd(3'd4);
    wr(3'd3, 8'h04); wr(3'd2, 8'h00); cmd(8'hA1); idle(1); wr(3'd2, 8'h01); idle(6);
    wr(3'd2, 8'h00); cmd(8'hA1); idle(7);

    sect = "R7 skip zero-suppression tag";
    wr(3'd3, 8'h01); wr(3'd2, 8'h02); cmd(8'hA3); idle(4);
    wr(3'd2, 8'h00); cmd(8'hA2); idle(4);

    sect = "R2 ignored bytes and masked types";
    wr(3'd1, 8'h05);
    cmd(8'hA1); idle(4); cmd(8'hA3); idle(4); cmd(8'h5A); cmd(8'hB0); cmd(8'h0A); idle(6);
    step(0, 8'hA0, 0, 3'd4, 8'h00); idle(6);
    cmd(8'hAE); idle(8); rd(3'd4);

    sect = "R2 R3 R5 R9 random";
    for (int i = 0; i < 2500; i++) begin
      int r = int'($urandom_range(99));
      logic [7:0] b;
      if (r < 55) b = {4'hA, 4'($urandom_range(15))};
      else if (r < 60) b = {4'hC, 4'($urandom_range(15))};
      else b = 8'($urandom_range(255));
      if ($urandom_range(99) < 7) begin
        logic [2:0] a = 3'($urandom_range(5));
        logic [7:0] d = 8'($urandom_range(255));
        if (a == 3'd2) d[0] = ($urandom_range(3) == 0);
        step($urandom_range(99) < 40, b, 1, a, d);
      end else begin
        step($urandom_range(99) < 45, b, 0, 3'($urandom_range(7)), 8'h00);
      end
    end

    summary();
    $finish;
  end
endmodule